// File: doc/BRIEF.md
# Polled Status Flag Bus Sequencer

This block decides when one buffer device may drive a status bus shared by several devices. Each device has a small group of almost-empty flags, one per queue. Only one device should drive the shared bus at any time. The block supports two ways of choosing that device, selected by a mode input.

In polled mode the devices form a ring. A token passes from each device's token output to the next device's token input. The device that takes the token on a read-clock edge places the flags it sampled at that edge on the bus for one cycle. During that cycle it raises its sync output and its token output. At reset the designated chain head holds a pending token, so the first edge after polling is enabled selects that device. A single device in polled mode feeds its token output back into its own token input, so it drives the bus on every cycle.

In direct mode an address strobe selects a device, and that device keeps driving the bus until a later strobe selects a different address. Strobes are ignored while the device is still being configured. When a device does not drive the bus, its bus outputs are forced to zero and its output-enable is low.

Top module: `pollbus_seq`

## Requirements
- R1: During reset and on the first cycle after it, status_oe, status_bus, token_out and sync are all 0.
- R2: A chain-head device (CHAIN_HEAD=1) in polled mode drives the bus from the first rising edge at which prog_busy is low, and not before. A device that is not the chain head never drives the bus without first receiving the token.
- R3: In polled mode, with prog_busy low, a rising edge at which token_in is 1 makes the device drive the bus for the following cycle. The bus then carries the queue_ae value sampled at that edge, with bit i being queue i.
- R4: In polled mode, sync and token_out are both 1 exactly in the cycles in which the device drives the bus.
- R5: When N devices are chained in a ring with device 0 as chain head, the k-th edge after polling starts (k = 1, 2, …) selects device (k-1) mod N. Exactly one device drives the bus in each cycle.
- R6: In direct mode, a rising edge with strobe 1, prog_busy 0 and sel_addr equal to DEV_ID selects the device. From then on, each cycle the bus carries the queue_ae value sampled at the previous edge.
- R7: In direct mode, an accepted strobe with a sel_addr other than DEV_ID deselects the device. With no strobe, the current selection is kept.
- R8: In direct mode, a strobe at an edge where prog_busy is 1 leaves the selection unchanged.
- R9: In direct mode, sync and token_out stay 0, and token_in has no effect on the bus.
- R10: In polled mode, strobe and sel_addr have no effect on the bus.
- R11: Whenever status_oe is 0, status_bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| polled_mode | input | 1 | 1 selects token-ring polling, 0 selects strobe-addressed selection |
| prog_busy | input | 1 | High while configuration is in progress; blocks strobes and the start of polling |
| token_in | input | 1 | Token from the previous device in the ring |
| strobe | input | 1 | Direct-mode selection strobe |
| sel_addr | input | ADDR_W | Device address compared with DEV_ID when the strobe is accepted |
| queue_ae | input | QUEUES | Per-queue almost-empty flags of this device |
| status_bus | output | QUEUES | Flag group driven onto the shared bus; zero when not owning |
| status_oe | output | 1 | High while this device owns the shared bus |
| token_out | output | 1 | Token pulse to the next device in the ring |
| sync | output | 1 | High during the cycle this device's status is on the bus in polled mode |

## Verification
Two functions can coincide on one edge: a token arriving and a strobe. The sweep in polled mode drives strobes with changing addresses on every edge while the token walks the four-device ring. Each device's enable and bus value must still match the arithmetic owner (k-1) mod 4 and the flag pattern computed for that edge. In direct mode the bench forces the token input of a self-looped device high while a strobe is active. It checks that the selection alone decides ownership and that sync and token_out stay low.

// File: rtl/pollbus_seq.sv
module pollbus_seq #(
  parameter int DEV_ID     = 0,
  parameter int ADDR_W     = 3,
  parameter int QUEUES     = 4,
  parameter bit CHAIN_HEAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              polled_mode,
  input  logic              prog_busy,
  input  logic              token_in,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [QUEUES-1:0] queue_ae,
  output logic [QUEUES-1:0] status_bus,
  output logic              status_oe,
  output logic              token_out,
  output logic              sync
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DEV_ID);

  logic              start_q;
  logic              own_q;
  logic              sel_q;
  logic [QUEUES-1:0] flags_q;

  wire poll_go   = polled_mode & ~prog_busy;
  wire strobe_ok = ~polled_mode & strobe & ~prog_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= CHAIN_HEAD;
      own_q   <= 1'b0;
      sel_q   <= 1'b0;
      flags_q <= '0;
    end else begin
      flags_q <= queue_ae;
      own_q   <= poll_go & (start_q | token_in);
      if (poll_go) start_q <= 1'b0;
      if (polled_mode) sel_q <= 1'b0;
      else if (strobe_ok) sel_q <= (sel_addr == MY_ADDR);
    end
  end

  assign status_oe  = polled_mode ? own_q : sel_q;
  assign status_bus = status_oe ? flags_q : '0;
  assign sync       = polled_mode & own_q;
  assign token_out  = polled_mode & own_q;

endmodule

// File: rtl/pollbus_seq_chk.sv
module pollbus_seq_chk #(
  parameter int DEV_ID = 0,
  parameter int ADDR_W = 3,
  parameter int QUEUES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              polled_mode,
  input logic              prog_busy,
  input logic              token_in,
  input logic              strobe,
  input logic [ADDR_W-1:0] sel_addr,
  input logic [QUEUES-1:0] queue_ae,
  input logic [QUEUES-1:0] status_bus,
  input logic              status_oe,
  input logic              token_out,
  input logic              sync
);

  AST_POLL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (polled_mode && token_in && !prog_busy) |=> (!polled_mode || (status_oe && status_bus == $past(queue_ae)))); // R3

  AST_SYNC_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> (status_oe && token_out)); // R4

  AST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled_mode && strobe && !prog_busy && sel_addr == ADDR_W'(DEV_ID)) |=> (polled_mode || status_oe)); // R6

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!polled_mode && prog_busy) ##1 !polled_mode |-> $stable(status_oe)); // R8

  AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !polled_mode |-> (!sync && !token_out)); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status_oe |-> (status_bus == '0)); // R11

endmodule

bind pollbus_seq pollbus_seq_chk #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W), .QUEUES(QUEUES)) u_chk (
  .clk(clk), .rst_n(rst_n), .polled_mode(polled_mode), .prog_busy(prog_busy),
  .token_in(token_in), .strobe(strobe), .sel_addr(sel_addr), .queue_ae(queue_ae),
  .status_bus(status_bus), .status_oe(status_oe), .token_out(token_out), .sync(sync)
);

// File: tb/tb_pollbus_seq.sv
module tb_pollbus_seq;
  localparam int NDEV = 4;
  localparam int SOLO = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic polled_mode = 1'b1;
  logic prog_busy = 1'b1;
  logic strobe = 1'b0;
  logic [2:0] sel_addr = '0;
  logic tok_force = 1'b0;

  logic [3:0] ae   [NDEV+1];
  logic [3:0] bus  [NDEV+1];
  logic       oe   [NDEV+1];
  logic       tok  [NDEV+1];
  logic       syn  [NDEV+1];
  logic       solo_tin;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  for (genvar k = 0; k < NDEV; k++) begin : g_ring
    pollbus_seq #(.DEV_ID(k), .ADDR_W(3), .QUEUES(4), .CHAIN_HEAD(k == 0)) u_dev (
      .clk(clk), .rst_n(rst_n), .polled_mode(polled_mode), .prog_busy(prog_busy),
      .token_in(tok[(k+NDEV-1)%NDEV]), .strobe(strobe), .sel_addr(sel_addr),
      .queue_ae(ae[k]), .status_bus(bus[k]), .status_oe(oe[k]),
      .token_out(tok[k]), .sync(syn[k]));
  end

  assign solo_tin = tok[NDEV] | tok_force;

  pollbus_seq #(.DEV_ID(SOLO), .ADDR_W(3), .QUEUES(4), .CHAIN_HEAD(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .polled_mode(polled_mode), .prog_busy(prog_busy),
    .token_in(solo_tin), .strobe(strobe), .sel_addr(sel_addr),
    .queue_ae(ae[NDEV]), .status_bus(bus[NDEV]), .status_oe(oe[NDEV]),
    .token_out(tok[NDEV]), .sync(syn[NDEV]));

  function automatic logic [3:0] pat(input int e, input int d);
    return 4'(e * 3 + d * 5 + 1);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_flags(input int e);
    for (int d = 0; d <= NDEV; d++) ae[d] = pat(e, d);
  endtask

  task automatic check_dev(input string req, input int d, input bit own, input logic [3:0] val, input bit pol);
    check(req, $sformatf("oe dev%0d", d), int'(oe[d]), int'(own));
    check(req, $sformatf("bus dev%0d", d), int'(bus[d]), own ? int'(val) : 0);
    check(req, $sformatf("sync dev%0d", d), int'(syn[d]), int'(own && pol));
    check(req, $sformatf("tok dev%0d", d), int'(tok[d]), int'(own && pol));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] held [NDEV+1];
    set_flags(0);
    repeat (3) @(negedge clk);
    for (int d = 0; d <= NDEV; d++) check_dev("R1", d, 1'b0, 4'd0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d <= NDEV; d++) check_dev("R1", d, 1'b0, 4'd0, 1'b1);
    repeat (2) begin
      @(negedge clk);
      for (int d = 0; d <= NDEV; d++) check_dev("R2", d, 1'b0, 4'd0, 1'b1);
    end

    // polled sweep: strobes and addresses churn alongside the token (R10)
    prog_busy = 1'b0;
    for (int e = 1; e <= 24; e++) begin
      set_flags(e);
      strobe   = e[0];
      sel_addr = 3'(e);
      @(negedge clk);
      for (int d = 0; d < NDEV; d++)
        check_dev(e == 1 ? "R2" : (e[0] ? "R5" : "R10"), d, d == (e - 1) % NDEV, pat(e, d), 1'b1);
      check_dev("R3", NDEV, 1'b1, pat(e, NDEV), 1'b1);
      check("R4", "sync count in ring", int'(syn[0]) + int'(syn[1]) + int'(syn[2]) + int'(syn[3]), 1);
    end

    // direct mode
    strobe = 1'b0;
    polled_mode = 1'b0;
    set_flags(40);
    @(negedge clk);
    for (int d = 0; d <= NDEV; d++) check_dev("R9", d, 1'b0, 4'd0, 1'b0);

    for (int a = 0; a < 8; a++) begin
      set_flags(50 + a);
      strobe = 1'b1;
      sel_addr = 3'(a);
      @(negedge clk);
      strobe = 1'b0;
      for (int d = 0; d <= NDEV; d++) held[d] = pat(50 + a, d);
      for (int d = 0; d < NDEV; d++) check_dev(d == a ? "R6" : "R7", d, d == a, held[d], 1'b0);
      check_dev(a == SOLO ? "R6" : "R7", NDEV, a == SOLO, held[NDEV], 1'b0);
      set_flags(70 + a);
      @(negedge clk);
      for (int d = 0; d < NDEV; d++) check_dev(d == a ? "R6" : "R7", d, d == a, pat(70 + a, d), 1'b0);
      check_dev(a == SOLO ? "R6" : "R7", NDEV, a == SOLO, pat(70 + a, NDEV), 1'b0);
    end

    strobe = 1'b1;
    sel_addr = 3'd2;
    @(negedge clk);
    prog_busy = 1'b1;
    sel_addr = 3'd1;
    @(negedge clk);
    strobe = 1'b0;
    for (int d = 0; d < NDEV; d++) check_dev("R8", d, d == 2, ae[d], 1'b0);
    prog_busy = 1'b0;

    // token forced high on the solo device while a strobe selects it (R9)
    tok_force = 1'b1;
    strobe = 1'b1;
    sel_addr = 3'(SOLO);
    set_flags(90);
    @(negedge clk);
    strobe = 1'b0;
    check_dev("R9", NDEV, 1'b1, pat(90, NDEV), 1'b0);
    strobe = 1'b1;
    sel_addr = 3'd0;
    @(negedge clk);
    strobe = 1'b0;
    check_dev("R9", NDEV, 1'b0, 4'd0, 1'b0);
    check_dev("R7", 0, 1'b1, pat(90, 0), 1'b0);
    for (int d = 0; d <= NDEV; d++) if (bus[d] != 4'd0 && !oe[d]) check("R11", "idle bus", int'(bus[d]), 0);
    check("R11", "idle bus dev3", int'(bus[3]), 0);
    tok_force = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule